// File: doc/BRIEF.md
# Software-Filled Translation Buffer with Page-Table Pointer Assist

This block is a small, fully associative address translation buffer that software fills. Software reaches it through one register port. Five registers hold staged state: a control word, a page-number word, a segment/walk word, a table-base word and a context number. When software writes a sixth register, the real-page word, the block builds one translation entry. It merges the new real-page word with the fields already staged in the page-number and segment/walk registers. The entry is stored in the slot that the control word names.

A lookup port translates an effective address in the same cycle, using the current context number. It reports hit or miss, the winning slot, the physical address and the page attributes. When a lookup misses, the block records the missing page in the page-number register. The miss handler can then read two pointers, each formed by shift-and-add from that page number:
- the first-level table base register returns the first-level descriptor address;
- the segment/walk register returns the second-level descriptor address.

Top module: `swtlb`

## Requirements
- R1: After reset, the control register reads 32'h0400_0000 (only bit 26 set), and every slot is empty, so every lookup misses.
- R2: Register select codes are 0 control, 1 page-number, 2 segment/walk, 3 real-page, 4 table-base and 5 context. The control and page-number registers read back exactly what was written. The context register keeps bits 3:0 and reads them back with zeros above. The real-page register and codes 6 and 7 read as zero.
- R3: A write with code 3 loads the slot given by control bits 12:8. The slot takes its page number (bits 31:12), valid flag (bit 9) and 4-bit context tag (bits 3:0) from the page-number register. It takes its group, guard, size, write-through and segment-valid fields from the segment/walk register. It takes its real page (bits 31:12) and small-page select (bit 3) from the written word.
- R4: Page size comes from segment/walk bits 3:2. Code 11 gives 8 MB and code 01 gives 512 KB. Any other code gives a small page: 16 KB when real-page bit 3 is set, otherwise 4 KB. A lookup compares only the address bits above the page offset.
- R5: A slot matches only when its context tag equals the context register.
- R6: A slot whose valid flag is clear never matches.
- R7: When several slots match, the lowest slot index is reported.
- R8: A lookup that misses loads the page-number register at the next clock edge with {address[31:12], 8'h00, context}. A software write to that register in the same cycle takes precedence.
- R9: Reading the table-base register returns {base[31:12], page[31:22], 2'b00}, where page is the page-number register.
- R10: Reading the segment/walk register returns {walk[31:12], 12'h000} + (page[21:12] * 4).
- R11: On a hit, the physical address takes the real page above the page offset and the lookup address within it. The group (segment/walk bits 8:5), guard (bit 4), write-through (bit 1) and segment-valid (bit 0) of the hit slot appear on the attribute outputs.
- R12: The hit output is never high while the lookup request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_sel) |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address to translate |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_index | output | IDX_W | Index of the winning slot |
| lk_pa | output | 32 | Translated physical address |
| lk_apg | output | 4 | Protection group of the hit slot |
| lk_guarded | output | 1 | Guard flag of the hit slot |
| lk_wt | output | 1 | Write-through flag of the hit slot |
| lk_seg_valid | output | 1 | Segment-valid flag of the hit slot |

## Verification
The bench fills all slots and then looks each one up.
- **Index decoding:** a wrong decode of control bits 12:8 sends entries to the wrong slot.
- **Page sizes:** for every size, the bench walks one bit at a time through the offset and then sets the first bit above it. A wrong size mask either leaks lookup bits into the physical address or matches a neighbouring page.
- **Overlapping slots:** the bench loads the same page into two slots and checks that the lower index wins. It then removes the lower one and checks that the higher one takes over.
- **Context and valid gating:** mismatched contexts and cleared valid flags must miss.
- **Miss capture and pointer reads:** the bench checks the page-number register after a miss and sweeps the table-base and segment/walk reads over several page numbers. A wrong shift, a wrong field or a missed capture shows up as a bad pointer.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_PAGE  = 3'd1,
    SEL_WALK  = 3'd2,
    SEL_REAL  = 3'd3,
    SEL_BASE  = 3'd4,
    SEL_CTX   = 3'd5
  } reg_sel_e;

  localparam logic [31:0] CTRL_RST = 32'h0400_0000;
  localparam int          CTX_W    = 4;

  typedef struct packed {
    logic             valid;
    logic [19:0]      page;
    logic [CTX_W-1:0] ctx;
    logic [3:0]       grp;
    logic             guard;
    logic [1:0]       size;
    logic             wthru;
    logic             segv;
    logic [19:0]      rpage;
    logic             big16;
  } slot_t;

  // Offset bits covered by a page of the given size code.
  function automatic logic [31:0] offset_mask(input logic [1:0] size, input logic big16);
    case (size)
      2'b11:   offset_mask = 32'h007F_FFFF;
      2'b01:   offset_mask = 32'h0007_FFFF;
      default: offset_mask = big16 ? 32'h0000_3FFF : 32'h0000_0FFF;
    endcase
  endfunction

  function automatic logic [31:0] l1_pointer(input logic [31:0] base, input logic [31:0] page);
    l1_pointer = {base[31:12], page[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] l2_pointer(input logic [31:0] walk, input logic [31:0] page);
    l2_pointer = {walk[31:12], 12'h000} + {20'h0, page[21:12], 2'b00};
  endfunction

  function automatic slot_t make_slot(input logic [31:0] page, input logic [31:0] walk,
                                      input logic [31:0] real_word);
    slot_t s;
    s.valid = page[9];
    s.page  = page[31:12];
    s.ctx   = page[CTX_W-1:0];
    s.grp   = walk[8:5];
    s.guard = walk[4];
    s.size  = walk[3:2];
    s.wthru = walk[1];
    s.segv  = walk[0];
    s.rpage = real_word[31:12];
    s.big16 = real_word[3];
    make_slot = s;
  endfunction

endpackage

// File: rtl/swtlb_regs.sv
module swtlb_regs
  import swtlb_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [2:0]          reg_sel,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                miss_cap,
  input  logic [19:0]         miss_page,
  output logic                slot_load,
  output logic [IDX_W-1:0]    slot_idx,
  output slot_t               slot_new,
  output logic [CTX_W-1:0]    ctx,
  output logic [31:0]         ctrl_q,
  output logic [31:0]         page_q
);

  logic [31:0]      walk_q;
  logic [31:0]      base_q;
  logic [CTX_W-1:0] ctx_q;
  logic             wr_page;

  assign wr_page   = reg_we && (reg_sel == SEL_PAGE);
  assign slot_load = reg_we && (reg_sel == SEL_REAL);
  assign slot_idx  = ctrl_q[8 +: IDX_W];
  assign slot_new  = make_slot(page_q, walk_q, reg_wdata);
  assign ctx       = ctx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      page_q <= '0;
      walk_q <= '0;
      base_q <= '0;
      ctx_q  <= '0;
    end else begin
      if (reg_we && reg_sel == SEL_CTRL) ctrl_q <= reg_wdata;
      if (reg_we && reg_sel == SEL_WALK) walk_q <= reg_wdata;
      if (reg_we && reg_sel == SEL_BASE) base_q <= reg_wdata;
      if (reg_we && reg_sel == SEL_CTX)  ctx_q  <= reg_wdata[CTX_W-1:0];
      if (wr_page)       page_q <= reg_wdata;
      else if (miss_cap) page_q <= {miss_page, 8'h00, ctx_q};
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = ctrl_q;
      SEL_PAGE: reg_rdata = page_q;
      SEL_WALK: reg_rdata = l2_pointer(walk_q, page_q);
      SEL_BASE: reg_rdata = l1_pointer(base_q, page_q);
      SEL_CTX:  reg_rdata = {{(32-CTX_W){1'b0}}, ctx_q};
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/swtlb_array.sv
module swtlb_array
  import swtlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  slot_t               wr_slot,
  input  logic                lk_valid,
  input  logic [31:0]         lk_ea,
  input  logic [CTX_W-1:0]    lk_ctx,
  output logic [ENTRIES-1:0]  hit_vec,
  output logic                hit,
  output logic [IDX_W-1:0]    hit_idx,
  output logic [19:0]         sel_rpage,
  output logic [31:0]         sel_mask,
  output logic [3:0]          sel_grp,
  output logic                sel_guard,
  output logic                sel_wthru,
  output logic                sel_segv
);

  slot_t slots [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic [31:0] mask;
    assign mask = offset_mask(slots[g].size, slots[g].big16);
    assign hit_vec[g] = lk_valid && slots[g].valid && (slots[g].ctx == lk_ctx) &&
                        (((lk_ea ^ {slots[g].page, 12'h000}) & ~mask) == 32'h0);

    always_ff @(posedge clk) begin
      if (!rst_n) slots[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g)) slots[g] <= wr_slot;
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit       = |hit_vec;
  assign sel_rpage = slots[hit_idx].rpage;
  assign sel_mask  = offset_mask(slots[hit_idx].size, slots[hit_idx].big16);
  assign sel_grp   = slots[hit_idx].grp;
  assign sel_guard = slots[hit_idx].guard;
  assign sel_wthru = slots[hit_idx].wthru;
  assign sel_segv  = slots[hit_idx].segv;

endmodule

// File: rtl/swtlb.sv
module swtlb
  import swtlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             lk_valid,
  input  logic [31:0]      lk_ea,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_index,
  output logic [31:0]      lk_pa,
  output logic [3:0]       lk_apg,
  output logic             lk_guarded,
  output logic             lk_wt,
  output logic             lk_seg_valid
);

  logic               slot_load;
  logic [IDX_W-1:0]   slot_idx;
  slot_t              slot_new;
  logic [CTX_W-1:0]   ctx;
  logic [31:0]        ctrl_q;
  logic [31:0]        page_q;
  logic [ENTRIES-1:0] hit_vec;
  logic               miss_cap;
  logic [19:0]        sel_rpage;
  logic [31:0]        sel_mask;

  assign miss_cap = lk_valid && !lk_hit;

  swtlb_regs #(.IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .miss_cap  (miss_cap),
    .miss_page (lk_ea[31:12]),
    .slot_load (slot_load),
    .slot_idx  (slot_idx),
    .slot_new  (slot_new),
    .ctx       (ctx),
    .ctrl_q    (ctrl_q),
    .page_q    (page_q)
  );

  swtlb_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (slot_load),
    .wr_idx    (slot_idx),
    .wr_slot   (slot_new),
    .lk_valid  (lk_valid),
    .lk_ea     (lk_ea),
    .lk_ctx    (ctx),
    .hit_vec   (hit_vec),
    .hit       (lk_hit),
    .hit_idx   (lk_index),
    .sel_rpage (sel_rpage),
    .sel_mask  (sel_mask),
    .sel_grp   (lk_apg),
    .sel_guard (lk_guarded),
    .sel_wthru (lk_wt),
    .sel_segv  (lk_seg_valid)
  );

  assign lk_pa = ({sel_rpage, 12'h000} & ~sel_mask) | (lk_ea & sel_mask);

endmodule

// File: rtl/swtlb_chk.sv
module swtlb_chk #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [31:0]        lk_ea,
  input logic               lk_hit,
  input logic [IDX_W-1:0]   lk_index,
  input logic [11:0]        lk_pa_low,
  input logic [ENTRIES-1:0] hit_vec,
  input logic               miss_cap,
  input logic               reg_we,
  input logic [2:0]         reg_sel,
  input logic [19:0]        page_top,
  input logic [31:0]        ctrl_q
);

  logic [ENTRIES-1:0] below;
  assign below = (ENTRIES'(1) << lk_index) - ENTRIES'(1);

  AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid); // R12

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (hit_vec[lk_index] && ((hit_vec & below) == '0))); // R7

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa_low == lk_ea[11:0])); // R11

  AST_MISS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cap && !(reg_we && reg_sel == 3'd1)) |=> (page_top == $past(lk_ea[31:12]))); // R8

  AST_CTRL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_q == 32'h0400_0000)); // R1

endmodule

bind swtlb swtlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_ea     (lk_ea),
  .lk_hit    (lk_hit),
  .lk_index  (lk_index),
  .lk_pa_low (lk_pa[11:0]),
  .hit_vec   (hit_vec),
  .miss_cap  (miss_cap),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .page_top  (page_q[31:12]),
  .ctrl_q    (ctrl_q)
);

// File: tb/swtlb_test.sv
module swtlb_test;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 32;
  localparam int IDX_W      = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_we = 1'b0;
  logic [2:0]       reg_sel = 3'd0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             lk_valid = 1'b0;
  logic [31:0]      lk_ea = '0;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_index;
  logic [31:0]      lk_pa;
  logic [3:0]       lk_apg;
  logic             lk_guarded, lk_wt, lk_seg_valid;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  logic             o_hit;
  logic [IDX_W-1:0] o_idx;
  logic [31:0]      o_pa;
  logic [6:0]       o_attr;
  logic [31:0]      rv;

  swtlb #(.ENTRIES(ENTRIES)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_index(lk_index), .lk_pa(lk_pa),
    .lk_apg(lk_apg), .lk_guarded(lk_guarded), .lk_wt(lk_wt),
    .lk_seg_valid(lk_seg_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic look(input logic [31:0] ea);
    @(negedge clk);
    lk_ea = ea; lk_valid = 1'b1;
    #1;
    o_hit = lk_hit; o_idx = lk_index; o_pa = lk_pa;
    o_attr = {lk_apg, lk_guarded, lk_wt, lk_seg_valid};
    lk_valid = 1'b0;
  endtask

  task automatic load(input int idx, input logic [31:0] pg, input logic [31:0] walk,
                      input logic [31:0] realw);
    wr(3'd0, 32'h0400_0000 | (32'(idx) << 8));
    wr(3'd1, pg);
    wr(3'd2, walk);
    wr(3'd3, realw);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    rd(3'd0, rv); check("R1 ctrl reset", rv, 32'h0400_0000);
    for (int k = 0; k < 4; k++) begin
      look(32'h0000_0000 + 32'(k) * 32'h4000_1000);
      check("R1 empty miss", {31'h0, o_hit}, 32'h0);
    end

    // R2: readback
    wr(3'd0, 32'hDEAD_1F00); rd(3'd0, rv); check("R2 ctrl", rv, 32'hDEAD_1F00);
    wr(3'd1, 32'h1357_9A4C); rd(3'd1, rv); check("R2 page", rv, 32'h1357_9A4C);
    wr(3'd5, 32'hFFFF_FFF7); rd(3'd5, rv); check("R2 ctx", rv, 32'h0000_0007);
    rd(3'd3, rv); check("R2 real reads zero", rv, 32'h0);
    rd(3'd6, rv); check("R2 code6 zero", rv, 32'h0);
    wr(3'd5, 32'h0);

    // R3: fill every slot with a 4 KB page, then look each up
    for (int i = 0; i < ENTRIES; i++)
      load(i, {20'h00100 + 20'(i), 12'h200}, 32'h1, {20'h00A00 + 20'(i), 12'h000});
    for (int i = 0; i < ENTRIES; i++) begin
      look({20'h00100 + 20'(i), 12'h5A4});
      check("R3 slot hit", {31'h0, o_hit}, 32'h1);
      check("R3 slot index", 32'(o_idx), 32'(i));
      check("R3 slot pa", o_pa, {20'h00A00 + 20'(i), 12'h5A4});
    end

    // R4: every page size, offset walk and first bit above
    for (int k = 0; k < 4; k++) begin
      int sh;
      logic [1:0] sz;
      logic b16;
      logic [31:0] va, pb, m, ea;
      sh  = (k == 0) ? 23 : (k == 1) ? 19 : (k == 2) ? 14 : 12;
      sz  = (k == 0) ? 2'b11 : (k == 1) ? 2'b01 : 2'b00;
      b16 = (k == 2);
      va  = 32'h8000_0000 + 32'(k) * 32'h0100_0000;
      pb  = 32'h0200_0000 * 32'(k + 1);
      m   = (32'h1 << sh) - 32'h1;
      load(10 + k, va | 32'h200, {28'h0, sz, 2'b01}, pb | {28'h0, b16, 3'b000});
      for (int b = 0; b < sh; b++) begin
        ea = va | (32'h1 << b);
        look(ea);
        check("R4 in-page hit", {31'h0, o_hit}, 32'h1);
        check("R4 in-page pa", o_pa, (pb & ~m) | (ea & m));
      end
      look(va | (32'h1 << sh));
      check("R4 above-page miss", {31'h0, o_hit}, 32'h0);
    end

    // R5: context tag
    wr(3'd5, 32'h5);
    look(32'h0010_0123); check("R5 ctx mismatch", {31'h0, o_hit}, 32'h0);
    load(20, 32'h6000_0205, 32'h1, 32'h0777_7000);
    look(32'h6000_0ABC); check("R5 ctx match", o_pa, 32'h0777_7ABC);
    wr(3'd5, 32'h0);
    look(32'h6000_0ABC); check("R5 ctx back to 0 miss", {31'h0, o_hit}, 32'h0);

    // R6: cleared valid flag
    load(7, 32'h5000_0000, 32'h1, 32'h0123_4000);
    look(32'h5000_0010); check("R6 invalid miss", {31'h0, o_hit}, 32'h0);
    look(32'h0010_7010); check("R6 overwritten miss", {31'h0, o_hit}, 32'h0);

    // R7: lowest index wins
    load(25, 32'h4000_0200, 32'h1, 32'h1111_1000);
    load(4,  32'h4000_0200, 32'h1, 32'h2222_2000);
    look(32'h4000_0ABC);
    check("R7 low index", 32'(o_idx), 32'd4);
    check("R7 low pa", o_pa, 32'h2222_2ABC);
    load(4, 32'h4400_0000, 32'h1, 32'h0);
    look(32'h4000_0ABC);
    check("R7 fallback index", 32'(o_idx), 32'd25);

    // R11: attributes
    load(30, 32'h7000_0200, 32'h0000_01F3, 32'h0999_9000);
    look(32'h7000_0001);
    check("R11 attrs set", 32'(o_attr), 32'b1111_1_1_1);
    load(30, 32'h7000_0200, 32'h0000_0001, 32'h0999_9000);
    look(32'h7000_0001);
    check("R11 attrs clear", 32'(o_attr), 32'b0000_0_0_1);

    // R12: no hit without request
    @(negedge clk); lk_ea = 32'h7000_0001; lk_valid = 1'b0; #1;
    check("R12 idle no hit", {31'h0, lk_hit}, 32'h0);

    // R8: miss capture
    wr(3'd5, 32'h9);
    @(negedge clk); lk_ea = 32'h1234_5678; lk_valid = 1'b1;
    @(negedge clk); lk_valid = 1'b0;
    rd(3'd1, rv); check("R8 miss capture", rv, 32'h1234_5009);
    wr(3'd5, 32'h0);

    // R9 / R10: pointer reads
    wr(3'd4, 32'hABCD_E123);
    wr(3'd2, 32'h0034_5FFF);
    for (int j = 0; j < 8; j++) begin
      logic [31:0] pg;
      pg = (32'(j + 1) * 32'h1357_9BDF) & 32'hFFFF_F000;
      wr(3'd1, pg);
      rd(3'd4, rv); check("R9 level-1 pointer", rv, 32'hABCD_E000 + ((pg >> 22) * 4));
      rd(3'd2, rv); check("R10 level-2 pointer", rv, 32'h0034_5000 + (((pg >> 12) & 32'h3FF) * 4));
    end

    finish_run();
  end
endmodule